// File: doc/BRIEF.md
# Adaptive Green-Phase Switch Decision Unit

This unit decides when the current phase of a two-arm signalised junction should end. It keeps a waiting-car count for each arm. An entry sensor raises the count and an exit sensor lowers it. The unit also times the current phase in ticks of a slow time base, so it can hold the phase between a programmable minimum and maximum time. When the phase should end, it sends a one-cycle switch request to the lamp sequencer. The sequencer tells the unit which arm is currently favoured and whether the current phase is a normal green or a protected left-turn arrow.

Between the two limits, a normal green phase ends early in three cases: the favoured arm has emptied, a queue-weighted score no longer favours it, or its queue has not moved for a fixed number of ticks. The score is kept in integer arithmetic scaled by 8, as follows. The weight code `a` (0..7) stands for a weight of 1 + a/8. The bias input is already scaled by 8. The score is `(8+a_fav)*n_fav + bias - 8*n_other`. The left-arrow phase has its own pair of limits. Between those limits, only the stall rule can end it.

The phase timer and the stall counter clear when a switch request is issued. All decisions are taken only on cycles where `tick` is high.

Top module: `phase_switch_ctrl`

## Requirements
- R1: On a clock edge, an entry pulse on an arm raises its count by one and an exit pulse lowers it by one. Both pulses together leave the count unchanged. Counts of arm 0 and arm 1 appear on `queue_a` and `queue_b`, and both are 0 after reset.
- R2: A count stays at 0 when an exit arrives at 0, and stays at 2^CNT_W-1 when an entry arrives at the maximum. It never wraps.
- R3: Let T be the number of ticks since the last switch or reset, as seen on a given tick. No switch is requested on a tick where T is below the active minimum. The active minimum is `min_go` for a green phase and `min_turn` for a left phase.
- R4: Once T is at or above the minimum, a switch is requested on the first tick where T is at or above the active maximum (`max_go` or `max_turn`).
- R5: In a green phase inside the window, a switch is requested on a tick where the favoured arm's count is 0.
- R6: In a green phase inside the window, a switch is requested when `(8+a)*n_fav + bias <= 8*n_other`. Here `a` is `wt_a` when `fav_arm`=0 and `wt_b` when `fav_arm`=1.
- R7: Inside the window, a switch is requested on a tick that follows STALL_TICKS (default 5) ticks without a change in the favoured arm's count. A change in the non-favoured count does not restart this stall interval. A change on the same cycle as a tick clears the interval after that tick's decision.
- R8: With `left_phase`=1, the window uses `min_turn`/`max_turn`. Inside that window, counts and score are ignored and only the stall rule or the maximum ends the phase.
- R9: After a switch request, T and the stall interval restart from 0.
- R10: `switch_req` is high for exactly the cycle after a deciding tick, and is never raised without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse; decisions taken here |
| car_in | input | 2 | Entry sensor pulse per arm (bit 0 = arm 0) |
| car_out | input | 2 | Exit sensor pulse per arm |
| fav_arm | input | 1 | Arm currently holding the phase |
| left_phase | input | 1 | 1 = left-arrow phase, 0 = green phase |
| min_go | input | TIME_W | Minimum ticks for a green phase |
| max_go | input | TIME_W | Maximum ticks for a green phase |
| min_turn | input | TIME_W | Minimum ticks for a left phase |
| max_turn | input | TIME_W | Maximum ticks for a left phase |
| wt_a | input | ALPHA_W | Weight code for arm 0 (weight 1 + code/8) |
| wt_b | input | ALPHA_W | Weight code for arm 1 |
| bias | input | BETA_W | Bias term, already scaled by 8 |
| switch_req | output | 1 | One-cycle request to end the phase |
| queue_a | output | CNT_W | Waiting-car count, arm 0 |
| queue_b | output | CNT_W | Waiting-car count, arm 1 |

## Verification
The collision that matters is a favoured-arm sensor pulse on the same cycle as a tick. That cycle both decides the phase and restarts the stall interval. The bench first lets four quiet ticks pass, then sends a tick and an entry pulse together, and expects no switch on that tick. It then expects exactly five further quiet ticks without a switch before the sixth one ends the phase. This shows the pulse was counted after the decision. Timer reset on a switch is judged the same way: after a forced switch, it checks that the minimum time is again honoured.

// File: rtl/phase_switch_ctrl.sv
module phase_switch_ctrl #(
  parameter int CNT_W       = 6,
  parameter int TIME_W      = 6,
  parameter int ALPHA_W     = 3,
  parameter int BETA_W      = 8,
  parameter int STALL_TICKS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         car_in,
  input  logic [1:0]         car_out,
  input  logic               fav_arm,
  input  logic               left_phase,
  input  logic [TIME_W-1:0]  min_go,
  input  logic [TIME_W-1:0]  max_go,
  input  logic [TIME_W-1:0]  min_turn,
  input  logic [TIME_W-1:0]  max_turn,
  input  logic [ALPHA_W-1:0] wt_a,
  input  logic [ALPHA_W-1:0] wt_b,
  input  logic [BETA_W-1:0]  bias,
  output logic               switch_req,
  output logic [CNT_W-1:0]   queue_a,
  output logic [CNT_W-1:0]   queue_b
);

  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TIME_W-1:0] T_MAX   = {TIME_W{1'b1}};
  localparam int ST_W   = $clog2(STALL_TICKS + 1);
  localparam logic [ST_W-1:0] ST_LIM = ST_W'(STALL_TICKS);
  localparam int PROD_W = CNT_W + ALPHA_W + 2;
  localparam int F_W    = (PROD_W > BETA_W ? PROD_W : BETA_W) + 1;

  logic [1:0][CNT_W-1:0] q, q_nxt;
  logic [1:0]            chg;
  logic [TIME_W-1:0]     t_cnt;
  logic [ST_W-1:0]       stall;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      q_nxt[i] = q[i];
      if (car_in[i] && !car_out[i] && q[i] != CNT_MAX) q_nxt[i] = q[i] + 1'b1;
      if (car_out[i] && !car_in[i] && q[i] != '0)      q_nxt[i] = q[i] - 1'b1;
      chg[i] = (q_nxt[i] != q[i]);
    end
  end

  logic [CNT_W-1:0]   n_fav, n_oth;
  logic [ALPHA_W-1:0] wt_fav;
  logic [F_W-1:0]     pos_term, neg_term;

  assign n_fav    = q[fav_arm];
  assign n_oth    = q[~fav_arm];
  assign wt_fav   = fav_arm ? wt_b : wt_a;
  assign pos_term = F_W'(n_fav) * F_W'({1'b1, wt_fav}) + F_W'(bias);
  assign neg_term = F_W'(n_oth) << ALPHA_W;

  logic [TIME_W-1:0] lo_lim, hi_lim;
  logic in_window, at_max, stalled, end_green, decide, fire;

  assign lo_lim    = left_phase ? min_turn : min_go;
  assign hi_lim    = left_phase ? max_turn : max_go;
  assign in_window = t_cnt >= lo_lim;
  assign at_max    = t_cnt >= hi_lim;
  assign stalled   = stall >= ST_LIM;
  assign end_green = (n_fav == '0) || (pos_term <= neg_term) || stalled;
  assign decide    = in_window && (at_max || (left_phase ? stalled : end_green));
  assign fire      = tick && decide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q          <= '0;
      t_cnt      <= '0;
      stall      <= '0;
      switch_req <= 1'b0;
    end else begin
      q          <= q_nxt;
      switch_req <= fire;
      if (fire)                       t_cnt <= '0;
      else if (tick && t_cnt != T_MAX) t_cnt <= t_cnt + 1'b1;
      if (fire || chg[fav_arm])        stall <= '0;
      else if (tick && stall != ST_LIM) stall <= stall + 1'b1;
    end
  end

  assign queue_a = q[0];
  assign queue_b = q[1];

  assert_cnt_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (car_in[0] && !car_out[0] && queue_a == CNT_MAX) |=> (queue_a == CNT_MAX));

  assert_cnt_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (car_out[1] && !car_in[1] && queue_b == '0) |=> (queue_b == '0));

  assert_no_early_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> ($past(t_cnt) >= $past(lo_lim)));

  assert_forced_at_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && t_cnt >= lo_lim && t_cnt >= hi_lim) |=> switch_req);

  assert_left_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && left_phase && t_cnt < max_turn && stall < ST_LIM) |=> !switch_req);

  assert_restart_after_switch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> (t_cnt == '0 && stall == '0));

  assert_req_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> $past(tick));

endmodule

// File: tb/phase_switch_ctrl_tb.sv
module phase_switch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0] car_in = '0, car_out = '0;
  logic fav_arm = 1'b0, left_phase = 1'b0;
  logic [5:0] min_go = '0, max_go = 6'd60, min_turn = '0, max_turn = 6'd60;
  logic [2:0] wt_a = '0, wt_b = '0;
  logic [7:0] bias = '0;
  logic switch_req;
  logic [5:0] queue_a, queue_b;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .car_in(car_in), .car_out(car_out),
    .fav_arm(fav_arm), .left_phase(left_phase), .min_go(min_go), .max_go(max_go),
    .min_turn(min_turn), .max_turn(max_turn), .wt_a(wt_a), .wt_b(wt_b), .bias(bias),
    .switch_req(switch_req), .queue_a(queue_a), .queue_b(queue_b));

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; car_in = '0; car_out = '0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cars(input int arm, input int n, input bit leave);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (leave) car_out[arm] = 1'b1; else car_in[arm] = 1'b1;
      @(negedge clk);
      car_out = '0; car_in = '0;
    end
  endtask

  task automatic tk(input bit exp, input string tag, input int ent_arm = -1);
    @(negedge clk);
    tick = 1'b1;
    if (ent_arm >= 0) car_in[ent_arm] = 1'b1;
    @(negedge clk);
    tick = 1'b0; car_in = '0;
    chk(switch_req, exp, tag);
  endtask

  task automatic t_reset();
    do_reset();
    chk(switch_req, 0, "R10 reset req");
    chk(queue_a, 0, "R1 reset queue_a");
    chk(queue_b, 0, "R1 reset queue_b");
  endtask

  task automatic t_count();
    do_reset();
    cars(0, 3, 0); chk(queue_a, 3, "R1 entries");
    cars(0, 1, 1); chk(queue_a, 2, "R1 exit");
    @(negedge clk); car_in[0] = 1'b1; car_out[0] = 1'b1;
    @(negedge clk); car_in = '0; car_out = '0;
    chk(queue_a, 2, "R1 both pulses");
    cars(1, 2, 0); chk(queue_b, 2, "R1 arm1 entries");
  endtask

  task automatic t_sat();
    do_reset();
    cars(1, 1, 1); chk(queue_b, 0, "R2 floor");
    cars(0, 70, 0); chk(queue_a, 63, "R2 ceiling");
    cars(0, 70, 1); chk(queue_a, 0, "R2 back to floor");
  endtask

  task automatic t_window();
    do_reset();
    min_go = 6'd3; max_go = 6'd6; fav_arm = 0; left_phase = 0; wt_a = 0; bias = 0;
    cars(0, 10, 0);
    for (int i = 1; i <= 6; i++) tk(0, i <= 3 ? "R3 below min" : "R4 below max", 0);
    tk(1, "R4 forced at max", 0);
    @(negedge clk); chk(switch_req, 0, "R10 single pulse");
    for (int i = 1; i <= 3; i++) tk(0, "R9 timer restarted", 0);
  endtask

  task automatic t_empty();
    do_reset();
    min_go = 6'd2; max_go = 6'd40; fav_arm = 0; left_phase = 0;
    tk(0, "R3 empty below min");
    tk(0, "R3 empty below min");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk(switch_req, 0, "R10 no tick no request");
    end
    tk(1, "R5 empty arm ends green");
  endtask

  task automatic t_score();
    min_go = 0; max_go = 6'd60; left_phase = 0;
    do_reset(); fav_arm = 0; wt_a = 3'd2; bias = 0;
    cars(0, 4, 0); cars(1, 5, 0); tk(1, "R6 score equal zero");
    do_reset(); cars(0, 4, 0); cars(1, 4, 0); tk(0, "R6 score positive");
    do_reset(); bias = 8'd1; cars(0, 4, 0); cars(1, 5, 0); tk(0, "R6 bias tips score");
    do_reset(); bias = 0; fav_arm = 1; wt_b = 0;
    cars(0, 5, 0); cars(1, 5, 0); tk(1, "R6 arm1 weight 1.0");
    do_reset(); wt_b = 3'd1; cars(0, 5, 0); cars(1, 5, 0); tk(0, "R6 arm1 weight 1.125");
    fav_arm = 0; wt_a = 0;
  endtask

  task automatic t_stall();
    do_reset();
    min_go = 0; max_go = 6'd60; fav_arm = 0; left_phase = 0; bias = 0;
    cars(0, 10, 0);
    for (int i = 0; i < 5; i++) tk(0, "R7 quiet ticks");
    tk(1, "R7 stall ends phase");
    for (int i = 0; i < 5; i++) tk(0, "R7 other arm moving", 1);
    tk(1, "R7 other arm does not restart");
    for (int i = 0; i < 4; i++) tk(0, "R7 quiet before collision");
    tk(0, "R7 tick with favoured entry", 0);
    for (int i = 0; i < 5; i++) tk(0, "R7 restarted after collision");
    tk(1, "R7 stall after collision");
  endtask

  task automatic t_left();
    do_reset();
    min_go = 0; max_go = 6'd60; fav_arm = 0; left_phase = 1;
    min_turn = 6'd2; max_turn = 6'd4;
    for (int i = 0; i < 4; i++) tk(0, "R8 left ignores empty arm");
    tk(1, "R8 left maximum");
    min_turn = 0; max_turn = 6'd30;
    for (int i = 0; i < 5; i++) tk(0, "R8 left before stall");
    tk(1, "R8 left stall");
    left_phase = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_sat();
    t_window();
    t_empty();
    t_score();
    t_stall();
    t_left();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule